// File: doc/BRIEF.md
# Vector step control instruction unit

This block carries out one vector stepping and status instruction against a small vector-state register that it holds itself. The register keeps a vector length, a sub-vector length code, a source and a destination element step, a source and a destination sub-element step, and two loop-order flags (pack for the source side, unpack for the destination side). A 7-bit selector picks the action: report one of four externally computed remap offsets, report one of the four step fields, rewrite the two loop-order flags, or (with step-enable high) advance both element iterators by one position.

The iterators walk a two-level loop of elements and sub-elements. With the loop-order flag clear the sub-element index is the inner loop; with it set the element index is the inner loop. Optional mask skipping moves an iterator past elements whose mask bit is zero. Each accepted instruction yields a registered 64-bit result, a 4-bit condition field whose EQ bit flags the final element of the loop, and a one-cycle done pulse. A separate load strobe sets the lengths and clears the step position.

Top module: `vstep_unit`

## Requirements
- R1: After reset the length field reads 1, the sub-vector code reads 0, all four step fields and both loop-order flags read 0, and out_done reads 0.
- R2: A cycle with ld_en high writes ld_vl and ld_subvl into the state and clears both steps, both substeps and both flags; an in_valid in that same cycle is dropped and gives no done pulse.
- R3: An instruction accepted with in_valid high (ld_en low) is answered on the next clock edge: out_done is high for exactly one cycle, with out_result and out_cr valid in that cycle.
- R4: When in_sel[3:2] is 2'b11 (whatever in_sel[6:4] and in_step are), the pack flag takes in_sel[0] and the unpack flag takes in_sel[1]; the result is zero apart from bit 0 (new pack) and bit 1 (new unpack); no step field changes.
- R5: Selector 1, 2, 3, 4 returns the zero-extended remap offset slot 0, 1, 2, 3, where slot k is shape_off[k*OFF_W +: OFF_W].
- R6: Selector 5, 6, 7, 8 returns the zero-extended source step, destination step, source substep and destination substep as they stood before the instruction.
- R7: Any non-zero selector that is not a flag command (including 9 to 11 and values from 16 up with in_sel[3:2] not 2'b11) leaves all step fields unchanged even with in_step high; selectors 9 to 11 and the other unlisted ones return 0.
- R8: With in_step low no step or substep field changes; selector 0 with in_step low and in_rec low gives result 0 and condition 0.
- R9: Selector 0 with in_step high returns 0 and advances each side once. With its flag clear: the substep counts up to the sub-vector code, then wraps to 0 while the element step moves to its next position, or to 0 after the last position.
- R10: With the side's flag set, the element step moves to its next position; after the last position it wraps to 0 and the substep counts up, wrapping to 0 after it equals the sub-vector code.
- R11: With src_skip (dst_skip) high, the next position is the lowest element above the current step and below the length whose src_mask (dst_mask) bit is 1; if none exists the step wraps as after the last position.
- R12: out_cr is {LT, GT, EQ, SO} from bit 3 down; with in_rec high EQ is 1 exactly when, before the instruction, the source step equals length-1 with source substep equal to the sub-vector code, or the same holds for the destination side; LT, GT, SO are always 0 and in_rec low gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load lengths and clear the step position |
| ld_vl | input | $clog2(MAXVL)+1 | Vector length to load, 1 to MAXVL |
| ld_subvl | input | 2 | Sub-vector code to load (elements per group minus one) |
| in_valid | input | 1 | Instruction strobe |
| in_sel | input | 7 | Mode selector |
| in_step | input | 1 | Step-enable |
| in_rec | input | 1 | Record bit, enables the condition field |
| shape_off | input | 4*OFF_W | Four remap offsets, slot k at bits k*OFF_W upward |
| src_mask | input | MAXVL | Source element mask |
| dst_mask | input | MAXVL | Destination element mask |
| src_skip | input | 1 | Skip masked-out source elements |
| dst_skip | input | 1 | Skip masked-out destination elements |
| out_done | output | 1 | One-cycle answer pulse |
| out_result | output | RES_W | Registered result |
| out_cr | output | 4 | Registered condition field |
| st_vl | output | $clog2(MAXVL)+1 | Current vector length |
| st_subvl | output | 2 | Current sub-vector code |
| st_src | output | $clog2(MAXVL) | Current source step |
| st_dst | output | $clog2(MAXVL) | Current destination step |
| st_ssub | output | 2 | Current source substep |
| st_dsub | output | 2 | Current destination substep |
| st_pack | output | 1 | Source loop-order flag |
| st_unpack | output | 1 | Destination loop-order flag |

## Verification
Stepping is tried with short lengths and every sub-vector code under both loop orders, which separates inner-substep walking from inner-element walking and exposes any swap of the two flags between sides. Random masks with skipping on and off tell a plain increment apart from the search for the next enabled element, including the case with no enabled element left, and a full-length run checks the top element. Queries with step-enable high on non-zero selectors and with it low on selector 0 show that only the one stepping encoding moves the state, while the record bit is toggled at loop ends to pin down EQ against the pre-instruction state.

// File: rtl/vstep_unit.sv
module vstep_unit #(
  parameter int MAXVL = 64,
  parameter int OFF_W = 16,
  parameter int RES_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_en,
  input  logic [$clog2(MAXVL):0]       ld_vl,
  input  logic [1:0]                   ld_subvl,
  input  logic                         in_valid,
  input  logic [6:0]                   in_sel,
  input  logic                         in_step,
  input  logic                         in_rec,
  input  logic [4*OFF_W-1:0]           shape_off,
  input  logic [MAXVL-1:0]             src_mask,
  input  logic [MAXVL-1:0]             dst_mask,
  input  logic                         src_skip,
  input  logic                         dst_skip,
  output logic                         out_done,
  output logic [RES_W-1:0]             out_result,
  output logic [3:0]                   out_cr,
  output logic [$clog2(MAXVL):0]       st_vl,
  output logic [1:0]                   st_subvl,
  output logic [$clog2(MAXVL)-1:0]     st_src,
  output logic [$clog2(MAXVL)-1:0]     st_dst,
  output logic [1:0]                   st_ssub,
  output logic [1:0]                   st_dsub,
  output logic                         st_pack,
  output logic                         st_unpack
);
  localparam int SW = $clog2(MAXVL);
  localparam int LW = SW + 1;

  logic [LW-1:0]    vl_q;
  logic [1:0]       subvl_q, ssub_q, dsub_q, ssub_n, dsub_n;
  logic [SW-1:0]    src_q, dst_q, src_n, dst_n;
  logic             pack_q, unpack_q, done_q;
  logic [RES_W-1:0] res_q, res_n;
  logic [3:0]       cr_q;
  logic [SW:0]      src_hit, dst_hit;
  logic [LW-1:0]    last_pos;
  logic [1:0]       shp;
  logic             is_flag_cmd, do_step, loop_end, take;

  function automatic logic [SW:0] seek(input logic [SW-1:0] cur, input logic [LW-1:0] len,
                                       input logic [MAXVL-1:0] m, input logic sk);
    logic [SW:0] r;
    r = '0;
    for (int j = MAXVL - 1; j >= 0; j--) begin
      logic [LW-1:0] jj;
      jj = LW'(j);
      if (jj > {1'b0, cur} && jj < len && (!sk || m[j])) r = {1'b1, jj[SW-1:0]};
    end
    return r;
  endfunction

  assign is_flag_cmd = (in_sel[3:2] == 2'b11);
  assign do_step     = in_step && (in_sel == 7'd0);
  assign take        = in_valid && !ld_en;
  assign last_pos    = vl_q - LW'(1);
  assign loop_end    = ({1'b0, src_q} == last_pos && ssub_q == subvl_q) ||
                       ({1'b0, dst_q} == last_pos && dsub_q == subvl_q);
  assign src_hit     = seek(src_q, vl_q, src_mask, src_skip);
  assign dst_hit     = seek(dst_q, vl_q, dst_mask, dst_skip);
  assign shp         = 2'(in_sel - 7'd1);

  always_comb begin
    src_n  = src_q;
    ssub_n = ssub_q;
    if (pack_q) begin
      if (src_hit[SW]) src_n = src_hit[SW-1:0];
      else begin
        src_n  = '0;
        ssub_n = (ssub_q == subvl_q) ? 2'd0 : ssub_q + 2'd1;
      end
    end else if (ssub_q != subvl_q) begin
      ssub_n = ssub_q + 2'd1;
    end else begin
      ssub_n = 2'd0;
      src_n  = src_hit[SW] ? src_hit[SW-1:0] : '0;
    end
  end

  always_comb begin
    dst_n  = dst_q;
    dsub_n = dsub_q;
    if (unpack_q) begin
      if (dst_hit[SW]) dst_n = dst_hit[SW-1:0];
      else begin
        dst_n  = '0;
        dsub_n = (dsub_q == subvl_q) ? 2'd0 : dsub_q + 2'd1;
      end
    end else if (dsub_q != subvl_q) begin
      dsub_n = dsub_q + 2'd1;
    end else begin
      dsub_n = 2'd0;
      dst_n  = dst_hit[SW] ? dst_hit[SW-1:0] : '0;
    end
  end

  always_comb begin
    res_n = '0;
    if (is_flag_cmd) res_n[1:0] = {in_sel[1], in_sel[0]};
    else begin
      case (in_sel)
        7'd1, 7'd2, 7'd3, 7'd4: res_n = RES_W'(shape_off[shp*OFF_W +: OFF_W]);
        7'd5: res_n = RES_W'(src_q);
        7'd6: res_n = RES_W'(dst_q);
        7'd7: res_n = RES_W'(ssub_q);
        7'd8: res_n = RES_W'(dsub_q);
        default: res_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q     <= LW'(1);
      subvl_q  <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      ssub_q   <= '0;
      dsub_q   <= '0;
      pack_q   <= 1'b0;
      unpack_q <= 1'b0;
      done_q   <= 1'b0;
      res_q    <= '0;
      cr_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (ld_en) begin
        vl_q     <= ld_vl;
        subvl_q  <= ld_subvl;
        src_q    <= '0;
        dst_q    <= '0;
        ssub_q   <= '0;
        dsub_q   <= '0;
        pack_q   <= 1'b0;
        unpack_q <= 1'b0;
      end else if (in_valid) begin
        done_q <= 1'b1;
        res_q  <= res_n;
        cr_q   <= {2'b00, in_rec & loop_end, 1'b0};
        if (is_flag_cmd) begin
          pack_q   <= in_sel[0];
          unpack_q <= in_sel[1];
        end
        if (do_step) begin
          src_q  <= src_n;
          ssub_q <= ssub_n;
          dst_q  <= dst_n;
          dsub_q <= dsub_n;
        end
      end
    end
  end

  assign out_done   = done_q;
  assign out_result = res_q;
  assign out_cr     = cr_q;
  assign st_vl      = vl_q;
  assign st_subvl   = subvl_q;
  assign st_src     = src_q;
  assign st_dst     = dst_q;
  assign st_ssub    = ssub_q;
  assign st_dsub    = dsub_q;
  assign st_pack    = pack_q;
  assign st_unpack  = unpack_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ld_en) |=> out_done);
  // R2
  load_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !out_done && st_src == '0 && st_dst == '0 && !st_pack && !st_unpack);
  // R8
  query_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ld_en && !in_step) |=> $stable(st_src) && $stable(st_dst) &&
                                        $stable(st_ssub) && $stable(st_dsub));
  // R4
  flag_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ld_en && in_sel[3:2] == 2'b11) |=>
      out_result == RES_W'({st_unpack, st_pack}));
  // R12
  cr_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> out_cr[3] == 1'b0 && out_cr[2] == 1'b0 && out_cr[0] == 1'b0);
  // R9
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, st_src} < st_vl && {1'b0, st_dst} < st_vl &&
    st_ssub <= st_subvl && st_dsub <= st_subvl);
endmodule

// File: tb/vstep_unit_tb.sv
module vstep_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXVL = 64;
  localparam int OFF_W = 16;
  localparam int RES_W = 64;
  localparam int SW = $clog2(MAXVL);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [SW:0] ld_vl = '0;
  logic [1:0] ld_subvl = '0;
  logic in_valid = 1'b0, in_step = 1'b0, in_rec = 1'b0;
  logic [6:0] in_sel = '0;
  logic [4*OFF_W-1:0] shape_off = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic src_skip = 1'b0, dst_skip = 1'b0;
  logic out_done;
  logic [RES_W-1:0] out_result;
  logic [3:0] out_cr;
  logic [SW:0] st_vl;
  logic [1:0] st_subvl, st_ssub, st_dsub;
  logic [SW-1:0] st_src, st_dst;
  logic st_pack, st_unpack;

  int checks = 0, errors = 0;
  int m_vl, m_subvl, m_src, m_dst, m_ss, m_ds;
  bit m_pk, m_up;

  always #(CLK_PERIOD/2) clk = ~clk;

  vstep_unit #(.MAXVL(MAXVL), .OFF_W(OFF_W), .RES_W(RES_W)) u_dut (
    .clk, .rst_n, .ld_en, .ld_vl, .ld_subvl, .in_valid, .in_sel, .in_step, .in_rec,
    .shape_off, .src_mask, .dst_mask, .src_skip, .dst_skip, .out_done, .out_result,
    .out_cr, .st_vl, .st_subvl, .st_src, .st_dst, .st_ssub, .st_dsub, .st_pack, .st_unpack);

  task automatic chk(string tag, string what, longint unsigned got, longint unsigned exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk(tag, "vl", st_vl, m_vl);
    chk(tag, "subvl", st_subvl, m_subvl);
    chk(tag, "src step", st_src, m_src);
    chk(tag, "dst step", st_dst, m_dst);
    chk(tag, "src substep", st_ssub, m_ss);
    chk(tag, "dst substep", st_dsub, m_ds);
    chk(tag, "pack", st_pack, m_pk);
    chk(tag, "unpack", st_unpack, m_up);
  endtask

  // Loop walk as the requirements describe it, one element at a time.
  task automatic walk(inout int s, inout int sub, input bit outer, input logic [MAXVL-1:0] m,
                      input bit sk);
    if (!outer && sub != m_subvl) begin
      sub++;
      return;
    end
    if (!outer) sub = 0;
    while (1) begin
      if (s == m_vl - 1) begin
        s = 0;
        if (outer) sub = (sub == m_subvl) ? 0 : sub + 1;
        break;
      end
      s++;
      if (!sk || m[s]) break;
    end
  endtask

  task automatic do_load(int vl, int subvl, bit with_valid);
    @(negedge clk);
    chk("R3", "done low before load", out_done, 0);
    ld_en = 1'b1; ld_vl = (SW+1)'(vl); ld_subvl = 2'(subvl);
    in_valid = with_valid; in_sel = 7'd5;
    @(negedge clk);
    ld_en = 1'b0; in_valid = 1'b0;
    m_vl = vl; m_subvl = subvl; m_src = 0; m_dst = 0; m_ss = 0; m_ds = 0; m_pk = 0; m_up = 0;
    chk("R2", "done after load", out_done, 0);
    check_state("R2");
  endtask

  task automatic op(string tag, int sel, bit step, bit rec);
    longint unsigned er;
    int ecr;
    bit le;
    @(negedge clk);
    chk("R3", "done dropped", out_done, 0);
    shape_off = {$urandom, $urandom};
    le = (m_src == m_vl - 1 && m_ss == m_subvl) || (m_dst == m_vl - 1 && m_ds == m_subvl);
    ecr = rec ? (le ? 2 : 0) : 0;
    er = 0;
    if (sel[3:2] == 2'b11) begin
      m_pk = sel[0]; m_up = sel[1];
      er = {sel[1], sel[0]};
    end else if (sel >= 1 && sel <= 4) er = (shape_off >> ((sel - 1) * OFF_W)) & 16'hFFFF;
    else if (sel == 5) er = m_src;
    else if (sel == 6) er = m_dst;
    else if (sel == 7) er = m_ss;
    else if (sel == 8) er = m_ds;
    if (sel == 0 && step) begin
      walk(m_src, m_ss, m_pk, src_mask, src_skip);
      walk(m_dst, m_ds, m_up, dst_mask, dst_skip);
    end
    in_valid = 1'b1; in_sel = 7'(sel); in_step = step; in_rec = rec;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3", "done pulse", out_done, 1);
    chk(tag, "result", out_result, er);
    chk("R12", "condition", out_cr, ecr);
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_vl = 1; m_subvl = 0; m_src = 0; m_dst = 0; m_ss = 0; m_ds = 0; m_pk = 0; m_up = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done at reset", out_done, 0);
    check_state("R1");

    // R2: load with a simultaneous strobe
    do_load(3, 1, 1'b1);

    // R9: inner substep walk, vl=3 subvl code 1
    op("R12", 0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) op("R9", 0, 1'b1, 1'b1);
    chk("R9", "walk wrapped src", st_src, 0);
    chk("R9", "walk wrapped substep", st_ssub, 0);
    op("R8", 0, 1'b0, 1'b0);

    // R4: flag commands, including upper selector bits set
    op("R4", 12, 1'b1, 1'b0);
    op("R4", 13, 1'b0, 1'b0);
    op("R4", 7'h7E, 1'b1, 1'b0);
    op("R4", 15, 1'b0, 1'b1);
    // R10: outer substep walk on both sides
    for (int i = 0; i < 7; i++) op("R10", 0, 1'b1, 1'b1);
    chk("R10", "outer walk src", st_src, 1);
    chk("R10", "outer walk substep", st_ssub, 0);

    // R5 R6 R7
    for (int s = 1; s <= 11; s++) op(s <= 4 ? "R5" : (s <= 8 ? "R6" : "R7"), s, 1'b1, 1'b0);
    op("R7", 7'h50, 1'b1, 1'b0);

    // R11: skipping with a sparse mask on a full-length vector
    do_load(MAXVL, 0, 1'b0);
    src_mask = '0; src_mask[5] = 1'b1; src_mask[MAXVL-1] = 1'b1; src_skip = 1'b1;
    dst_mask = '0; dst_skip = 1'b1;
    op("R11", 0, 1'b1, 1'b0);
    chk("R11", "skip to first set", st_src, 5);
    chk("R11", "no set bit wraps", st_dst, 0);
    op("R11", 0, 1'b1, 1'b0);
    chk("R11", "skip to top", st_src, MAXVL - 1);
    op("R12", 0, 1'b1, 1'b1);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r, sel;
      string tag;
      if ($urandom_range(0, 24) == 0)
        do_load($urandom_range(0, 7) == 0 ? MAXVL : $urandom_range(1, 9), $urandom_range(0, 3), 1'(($urandom)));
      src_mask = {$urandom, $urandom};
      dst_mask = {$urandom, $urandom};
      src_skip = 1'($urandom); dst_skip = 1'($urandom);
      r = $urandom_range(0, 99);
      if (r < 50) sel = 0;
      else if (r < 90) sel = $urandom_range(1, 15);
      else sel = $urandom_range(16, 127);
      if (sel[3:2] == 2'b11) tag = "R4";
      else if (sel >= 1 && sel <= 4) tag = "R5";
      else if (sel >= 5 && sel <= 8) tag = "R6";
      else if (sel != 0) tag = "R7";
      else if (src_skip || dst_skip) tag = "R11";
      else if (m_pk || m_up) tag = "R10";
      else tag = "R9";
      op(tag, sel, 1'($urandom_range(0, 3) != 0), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule